// File: doc/BRIEF.md
# Four-Stage Pipeline Sequencer with Decode-Stage Token Injection

This block steers instruction tokens through a fixed, in-order pipeline of four stages: fetch, decode, execute and write-back. Each token carries only a valid bit, an injected flag and a tag. No operand datapath is modelled. Every token visits every stage, one stage per cycle, whether or not that stage has real work for it. With the pipeline full, one instruction completes each cycle.

Some instructions need more than one machine cycle, and the block supplies those cycles by placing machine-generated filler tokens into decode right behind them. Interrupts work the same way. When a request is seen at an instruction boundary, the block places two generated tokens that carry the interrupt vector into decode. Generated tokens travel through execute and write-back like ordinary ones. While they enter decode, the instruction waiting in fetch is held there, and the fetch-stall output tells the instruction source to keep its next word. Only ordinary instructions that leave write-back raise the retire strobe.

Top module: `pipe_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, all four stages become empty after that edge. Once reset has emptied the pipeline, `retire`, `fetch_stall` and `irq_ack` stay low as long as no input is presented.
- R2: A word offered with `in_valid` high when `fetch_stall` is low is captured into fetch at the next edge. With an extra-cycle count of 0 it then occupies decode, execute and write-back on the three following edges. `retire` is high in the cycle after the fourth edge.
- R3: Words offered on consecutive cycles with extra-cycle count 0 never raise `fetch_stall`. After the first fill they retire one per cycle, in the order they were offered.
- R4: An ordinary instruction with extra-cycle count N (0 to 3) that enters decode is followed into decode by exactly N tokens on the next N edges. Each of these tokens has its injected flag set and carries the instruction's tag.
- R5: While generated tokens are entering decode, a word held in fetch keeps its tag and `fetch_stall` is high. The word enters decode as an ordinary token at the edge after the last generated token, exactly once.
- R6: Injected tokens pass through execute and write-back with their flag still set, and `retire` stays low while such a token sits in write-back.
- R7: When `irq_req` is high at an instruction boundary, `irq_ack` is high in that same cycle. On that edge and the next one, two injected tokens whose tag is `irq_vec` enter decode, while fetch holds its word.
- R8: An interrupt is not taken while a multi-cycle instruction still has generated tokens to insert. `irq_ack` stays low until the last of them has entered decode.
- R9: Execute and write-back have no stall. At each edge, execute takes what decode held and write-back takes what execute held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetched word is offered |
| in_tag | input | TAG_W (8) | ID of the offered word |
| in_extra | input | XC_W (2) | Extra machine cycles the offered word needs |
| irq_req | input | 1 | Interrupt request, held until acknowledged |
| irq_vec | input | TAG_W (8) | Interrupt vector, placed in the generated tokens |
| stg_valid | output | NSTAGE (4) | Per-stage occupancy; bit 0 fetch, 1 decode, 2 execute, 3 write-back |
| stg_inj | output | NSTAGE (4) | Per-stage injected flag, same bit order |
| stg_tag | output | NSTAGE*TAG_W (32) | Per-stage tag; stage i in bits [i*TAG_W +: TAG_W] |
| fetch_stall | output | 1 | Fetch holds its word; an offered word is not taken |
| irq_ack | output | 1 | The interrupt is taken at the coming edge |
| retire | output | 1 | An ordinary instruction is in write-back |

## Verification
The assertions assume that the source keeps `irq_req` high until it sees `irq_ack` and lowers it right after that edge. A request still held after the acknowledging edge would be read as a second interrupt. They also assume that an offered word is counted as taken only in a cycle where `fetch_stall` is low. The bench lowers `irq_req` in the cycle after every acknowledge. It offers new words only when it knows fetch is free, and it drops `in_valid` right after the word has been captured.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;

    parameter int TAG_W      = 8;
    parameter int XC_W       = 2;
    parameter int NSTAGE     = 4;
    parameter int IRQ_TOKENS = 2;

    localparam int IRQ_CW = (IRQ_TOKENS > 1) ? $clog2(IRQ_TOKENS) : 1;
    localparam int CNT_W  = (XC_W > IRQ_CW) ? XC_W : IRQ_CW;
    localparam int LAST_STG = NSTAGE - 1;

    typedef struct packed {
        logic             valid;
        logic             inj;
        logic [TAG_W-1:0] tag;
    } tok_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [XC_W-1:0]  extra;
    } fslot_t;

    function automatic tok_t mk_tok(input logic v, input logic i,
                                    input logic [TAG_W-1:0] t);
        tok_t r;
        r.valid = v;
        r.inj   = i;
        r.tag   = t;
        return r;
    endfunction

    function automatic tok_t bubble();
        return mk_tok(1'b0, 1'b0, '0);
    endfunction

endpackage

// File: rtl/pipe_fetch_slot.sv
module pipe_fetch_slot
    import pipe_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [XC_W-1:0]  in_extra,
    input  logic             adv,
    output fslot_t           slot,
    output logic             stall
);

    assign stall = slot.valid && !adv;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (!stall) begin
            slot.valid <= in_valid;
            slot.tag   <= in_valid ? in_tag   : '0;
            slot.extra <= in_valid ? in_extra : '0;
        end
    end

    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (slot.valid && slot.tag == $past(slot.tag)
                   && slot.extra == $past(slot.extra)));

endmodule

// File: rtl/pipe_inject_ctrl.sv
module pipe_inject_ctrl
    import pipe_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fslot_t           f_slot,
    input  logic             irq_req,
    input  logic [TAG_W-1:0] irq_vec,
    output tok_t             d_next,
    output logic             f_adv,
    output logic             irq_ack,
    output logic             inj_busy
);

    logic [CNT_W-1:0] cnt, cnt_n;
    logic [TAG_W-1:0] hold_tag, hold_tag_n;

    assign inj_busy = (cnt != '0);

    always_comb begin
        d_next     = bubble();
        cnt_n      = cnt;
        hold_tag_n = hold_tag;
        irq_ack    = 1'b0;
        f_adv      = 1'b0;
        if (cnt != '0) begin
            d_next = mk_tok(1'b1, 1'b1, hold_tag);
            cnt_n  = cnt - 1'b1;
        end else if (irq_req) begin
            d_next     = mk_tok(1'b1, 1'b1, irq_vec);
            cnt_n      = CNT_W'(IRQ_TOKENS - 1);
            hold_tag_n = irq_vec;
            irq_ack    = 1'b1;
        end else begin
            f_adv = 1'b1;
            if (f_slot.valid) begin
                d_next     = mk_tok(1'b1, 1'b0, f_slot.tag);
                cnt_n      = CNT_W'(f_slot.extra);
                hold_tag_n = f_slot.tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            hold_tag <= '0;
        end else begin
            cnt      <= cnt_n;
            hold_tag <= hold_tag_n;
        end
    end

    // R8
    irq_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (inj_busy && !$past(irq_ack)) |-> !irq_ack);

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
    import pipe_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  tok_t din,
    output tok_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= bubble();
        else     q <= din;
    end

endmodule

// File: rtl/pipe_sequencer.sv
module pipe_sequencer
    import pipe_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [XC_W-1:0]         in_extra,
    input  logic                    irq_req,
    input  logic [TAG_W-1:0]        irq_vec,
    output logic [NSTAGE-1:0]       stg_valid,
    output logic [NSTAGE-1:0]       stg_inj,
    output logic [NSTAGE*TAG_W-1:0] stg_tag,
    output logic                    fetch_stall,
    output logic                    irq_ack,
    output logic                    retire
);

    fslot_t f_slot;
    tok_t   d_next;
    logic   f_adv;
    logic   inj_busy;
    tok_t   stg [NSTAGE];

    pipe_fetch_slot u_fetch (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .in_extra (in_extra),
        .adv      (f_adv),
        .slot     (f_slot),
        .stall    (fetch_stall)
    );

    pipe_inject_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .f_slot   (f_slot),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .d_next   (d_next),
        .f_adv    (f_adv),
        .irq_ack  (irq_ack),
        .inj_busy (inj_busy)
    );

    assign stg[0] = mk_tok(f_slot.valid, 1'b0, f_slot.tag);

    for (genvar i = 1; i < NSTAGE; i++) begin : g_stage
        if (i == 1) begin : g_dec
            pipe_stage_reg u_reg (.clk(clk), .rst(rst), .din(d_next), .q(stg[i]));
        end else begin : g_fwd
            pipe_stage_reg u_reg (.clk(clk), .rst(rst), .din(stg[i-1]), .q(stg[i]));
        end
    end

    always_comb begin
        for (int i = 0; i < NSTAGE; i++) begin
            stg_valid[i]                = stg[i].valid;
            stg_inj[i]                  = stg[i].inj;
            stg_tag[i*TAG_W +: TAG_W]   = stg[i].tag;
        end
    end

    assign retire = stg[LAST_STG].valid && !stg[LAST_STG].inj;

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (stg_valid == '0));

    // R9
    exec_shift_chk: assert property (@(posedge clk) disable iff (rst)
        stg[1].valid |=> (stg[2] == $past(stg[1])));

    // R4
    inj_fill_chk: assert property (@(posedge clk) disable iff (rst)
        inj_busy |=> (stg[1].valid && stg[1].inj));

    // R7
    irq_token_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (stg[1].valid && stg[1].inj && stg[1].tag == $past(irq_vec)));

    // R5
    no_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (stg[0].valid && !fetch_stall) |=>
            (stg[1].valid && !stg[1].inj && stg[1].tag == $past(stg[0].tag)));

    // R6
    retire_src_chk: assert property (@(posedge clk) disable iff (rst)
        retire |-> $past(stg[2].valid && !stg[2].inj));

endmodule

// File: tb/sim_pipe_sequencer.sv
`timescale 1ns/1ps
module sim_pipe_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_tag = '0;
    logic [1:0]  in_extra = '0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [3:0]  stg_valid, stg_inj;
    logic [31:0] stg_tag;
    logic        fetch_stall, irq_ack, retire;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pipe_sequencer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_extra(in_extra), .irq_req(irq_req), .irq_vec(irq_vec),
        .stg_valid(stg_valid), .stg_inj(stg_inj), .stg_tag(stg_tag),
        .fetch_stall(fetch_stall), .irq_ack(irq_ack), .retire(retire)
    );

    function automatic logic [7:0] tag_at(input int i);
        return stg_tag[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        #1;
        chk("R1 valid", 32'(stg_valid), 32'h0);
        chk("R1 stall", 32'(fetch_stall), 32'h0);
        chk("R1 retire", 32'(retire), 32'h0);
        chk("R1 ack", 32'(irq_ack), 32'h0);
    endtask

    task automatic t_single();
        in_valid = 1'b1; in_tag = 8'h11; in_extra = 2'd0;
        #1 chk("R2 stall", 32'(fetch_stall), 32'h0);
        tick(); in_valid = 1'b0;
        chk("R2 fetch", 32'(stg_valid), 32'h1);
        chk("R2 ftag", 32'(tag_at(0)), 32'h11);
        tick();
        chk("R2 decode", 32'(stg_valid), 32'h2);
        tick();
        chk("R9 exec", 32'(stg_valid), 32'h4);
        chk("R9 etag", 32'(tag_at(2)), 32'h11);
        tick();
        chk("R2 wb", 32'(stg_valid), 32'h8);
        chk("R2 retire", 32'(retire), 32'h1);
        chk("R2 wtag", 32'(tag_at(3)), 32'h11);
        tick();
        chk("R2 drained", 32'(retire), 32'h0);
    endtask

    task automatic t_stream();
        for (int c = 0; c < 10; c++) begin
            in_valid = (c < 6);
            in_tag   = 8'h20 + 8'(c);
            in_extra = 2'd0;
            #1 if (c < 6) chk("R3 no stall", 32'(fetch_stall), 32'h0);
            tick();
            if (c >= 3 && c <= 8) begin
                chk("R3 retire", 32'(retire), 32'h1);
                chk("R3 order", 32'(tag_at(3)), 32'(8'h20 + 8'(c - 3)));
            end else begin
                chk("R3 idle", 32'(retire), 32'h0);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic t_multi_trace();
        in_valid = 1'b1; in_tag = 8'h30; in_extra = 2'd2;
        tick();
        in_tag = 8'h31; in_extra = 2'd0;
        #1 chk("R5 free", 32'(fetch_stall), 32'h0);
        tick();
        in_valid = 1'b0;
        #1 chk("R5 stall", 32'(fetch_stall), 32'h1);
        chk("R4 parent", 32'({stg_inj[1], tag_at(1)}), 32'h030);
        tick();
        chk("R4 fill1", 32'({stg_inj[1], tag_at(1)}), 32'h130);
        chk("R5 held", 32'({stg_valid[0], tag_at(0)}), 32'h131);
        chk("R5 stall2", 32'(fetch_stall), 32'h1);
        tick();
        chk("R4 fill2", 32'({stg_inj[1], tag_at(1)}), 32'h130);
        chk("R6 parent retire", 32'({retire, tag_at(3)}), 32'h130);
        tick();
        chk("R5 enters", 32'({stg_valid[1], stg_inj[1], tag_at(1)}), 32'h231);
        chk("R5 released", 32'(fetch_stall), 32'h0);
        tick();
        chk("R6 wb inj", 32'({stg_valid[3], stg_inj[3], retire}), 32'h6);
        tick();
        chk("R5 once", 32'({retire, tag_at(3)}), 32'h131);
        tick();
        chk("R5 no dup", 32'(stg_valid), 32'h0);
    endtask

    task automatic t_multi_count(input int n);
        int fills = 0, rets = 0, wb_inj = 0;
        in_valid = 1'b1; in_tag = 8'h60 + 8'(n); in_extra = 2'(n);
        tick();
        in_valid = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (stg_valid[1] && stg_inj[1] && tag_at(1) == 8'h60 + 8'(n)) fills++;
            if (retire) rets++;
            if (stg_valid[3] && stg_inj[3]) wb_inj++;
        end
        chk("R4 fill count", 32'(fills), 32'(n));
        chk("R6 retire count", 32'(rets), 32'h1);
        chk("R6 wb inj count", 32'(wb_inj), 32'(n));
    endtask

    task automatic t_irq();
        in_valid = 1'b1; in_tag = 8'h40; in_extra = 2'd0;
        tick();
        in_valid = 1'b0;
        irq_req = 1'b1; irq_vec = 8'hA5;
        #1 chk("R7 ack", 32'(irq_ack), 32'h1);
        chk("R7 stall", 32'(fetch_stall), 32'h1);
        tick();
        irq_req = 1'b0;
        #1 chk("R7 tok1", 32'({stg_inj[1], tag_at(1)}), 32'h1A5);
        chk("R7 held", 32'({stg_valid[0], tag_at(0)}), 32'h140);
        chk("R7 ack low", 32'(irq_ack), 32'h0);
        tick();
        chk("R7 tok2", 32'({stg_inj[1], tag_at(1)}), 32'h1A5);
        chk("R7 tok1 exec", 32'({stg_inj[2], tag_at(2)}), 32'h1A5);
        tick();
        chk("R7 word follows", 32'({stg_valid[1], stg_inj[1], tag_at(1)}), 32'h240);
        tick();
        chk("R6 irq wb", 32'({stg_inj[3], retire}), 32'h2);
        tick();
        chk("R7 word retires", 32'({retire, tag_at(3)}), 32'h140);
        tick();
    endtask

    task automatic t_irq_wait();
        in_valid = 1'b1; in_tag = 8'h50; in_extra = 2'd3;
        tick();
        in_valid = 1'b0;
        tick();
        irq_req = 1'b1; irq_vec = 8'h77;
        #1 chk("R8 wait0", 32'(irq_ack), 32'h0);
        tick();
        chk("R8 wait1", 32'(irq_ack), 32'h0);
        chk("R8 fill", 32'({stg_inj[1], tag_at(1)}), 32'h150);
        tick();
        chk("R8 wait2", 32'(irq_ack), 32'h0);
        tick();
        chk("R8 taken", 32'(irq_ack), 32'h1);
        tick();
        irq_req = 1'b0;
        #1 chk("R8 vec1", 32'({stg_inj[1], tag_at(1)}), 32'h177);
        tick();
        chk("R8 vec2", 32'({stg_inj[1], tag_at(1)}), 32'h177);
        repeat (4) tick();
        chk("R8 drained", 32'(stg_valid), 32'h0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_stream();
        repeat (2) tick();
        t_multi_trace();
        for (int n = 0; n < 4; n++) t_multi_count(n);
        t_irq();
        t_irq_wait();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule